// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the write strobes a host sends towards a flash device and turns valid unlock sequences into single commands for a program/erase engine. Each accepted write carries an address and a data byte. The decoder walks through a fixed handshake of writes to two unlock addresses, 5555h and 2AAAh. It recognises byte program, sector erase, block erase, chip erase, identification entry and identification exit. When it recognises a program or erase, it issues one pulse with the operation code, the target address and the final data byte.

Before a command leaves the block, two active-low pins gate it. One lock pin covers the top boot block and one write-protect pin covers every other block. A command aimed at a protected area is dropped without any report. A busy input from the engine freezes the decoder while an erase runs. While identification mode is active, a small read port returns the manufacturer and device codes.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `cmd_valid` is 0, `id_mode` is 0 and `id_code` is 00h.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h and then any (address, data) make `cmd_valid` high for exactly one cycle, in the cycle after the fourth write. In that cycle `cmd_op`=1 (program), `cmd_addr` is the fourth write's address and `cmd_data` is its data. This holds even when the data is F0h.
- R3: The erase prefix is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh. Following it with 30h at any address issues `cmd_op`=2 (sector erase). Following it with 50h issues `cmd_op`=3 (block erase). In both cases `cmd_addr` is that sixth write's address and `cmd_data` is its data.
- R4: Ending the erase prefix with 10h@5555h issues `cmd_op`=4 (chip erase), with `cmd_addr` set to that address, but only while `prog_mode` is 1. While `prog_mode` is 0, no command is issued.
- R5: Only address bits 15:0 take part in the unlock-address match, so the upper bits are ignored. Bit 15 must be 0: D555h is not treated as 5555h.
- R6: A write that does not match the expected step aborts the sequence and returns the decoder to standby without issuing a command. A later correct sequence still works.
- R7: The top boot block is the set of addresses whose bits above bit `BOOT_W`-1 are all ones. While `boot_lock_n` is 0, a program or erase with its target inside the top boot block is dropped.
- R8: While `wp_n` is 0, a program, sector erase or block erase with its target outside the top boot block is dropped.
- R9: While `erase_busy` is 1, writes have no effect. A sequence that is partly written stays where it was and completes normally after `erase_busy` returns to 0.
- R10: AAh@5555h, 55h@2AAAh, 90h@5555h sets `id_mode`. While `id_mode` is set, `id_code` is 9Dh for `id_offset`=0 and `DEV_CODE` for `id_offset`=1. While `id_mode` is clear, `id_code` is 00h.
- R11: `id_mode` is cleared by the three-write exit (AAh@5555h, 55h@2AAAh, F0h@5555h) or by one F0h write to any address from standby.
- R12: Chip erase is dropped while either `boot_lock_n` or `wp_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One write strobe per cycle when high |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| prog_mode | input | 1 | 1 selects the parallel programmer interface (chip erase allowed) |
| boot_lock_n | input | 1 | Low protects the top boot block |
| wp_n | input | 1 | Low protects all blocks except the boot block |
| erase_busy | input | 1 | Engine is erasing; writes are ignored |
| id_offset | input | 1 | Identification read offset (0 manufacturer, 1 device) |
| cmd_valid | output | 1 | One-cycle command pulse to the engine |
| cmd_op | output | 3 | 1 program, 2 sector erase, 3 block erase, 4 chip erase |
| cmd_addr | output | ADDR_W | Target address of the command |
| cmd_data | output | 8 | Data byte of the final write |
| id_mode | output | 1 | Identification mode active |
| id_code | output | 8 | Identification code for `id_offset` |

## Verification
Two functions can meet in the final cycle of a sequence: decoding the completed command and gating it by protection. The bench provokes this by completing program and erase sequences with the lock pins already low. It uses one target inside the boot block and one outside, so the same cycle either passes or drops the pulse. A second collision is the busy freeze against the sequence tracker. A stray write lands during `erase_busy` in the middle of an unlock sequence, and the bench then expects the command to finish exactly as if that write had never happened. The scoreboard judges each case by whether a pulse arrives and whether its fields match the queued expectation. Any pulse that arrives with nothing queued counts as a failure.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PROG = 3'd1,
    OP_SECT = 3'd2,
    OP_BLK  = 3'd3,
    OP_CHIP = 3'd4
  } fcd_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PGM, S_ERA1, S_ERA2, S_ERA3
  } fcd_state_e;

  localparam logic [15:0] UNLOCK_A = 16'h5555;
  localparam logic [15:0] UNLOCK_B = 16'h2AAA;
  localparam logic [7:0]  D_KEY1   = 8'hAA;
  localparam logic [7:0]  D_KEY2   = 8'h55;
  localparam logic [7:0]  D_PROG   = 8'hA0;
  localparam logic [7:0]  D_ERASE  = 8'h80;
  localparam logic [7:0]  D_IDIN   = 8'h90;
  localparam logic [7:0]  D_IDOUT  = 8'hF0;
  localparam logic [7:0]  D_SECT   = 8'h30;
  localparam logic [7:0]  D_BLK    = 8'h50;
  localparam logic [7:0]  D_CHIP   = 8'h10;
  localparam logic [7:0]  MFR_CODE = 8'h9D;

  // Unlock address match uses the low sixteen bits only.
  function automatic logic addr_hit(input logic [15:0] low, input logic [15:0] pat);
    return low == pat;
  endfunction

  // True when the address lies in the topmost block of size 2**blk_w.
  function automatic logic top_block(input logic [31:0] addr, input int aw, input int blk_w);
    logic hit;
    hit = 1'b1;
    for (int i = 0; i < 32; i++)
      if (i >= blk_w && i < aw && !addr[i]) hit = 1'b0;
    return hit;
  endfunction
endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              prog_mode,
  input  logic              erase_busy,
  output logic              req_valid,
  output fcd_op_e           req_op,
  output logic              id_enter,
  output logic              id_exit
);
  fcd_state_e st, nxt;
  logic take, at_a, at_b;

  assign take = wr_en & ~erase_busy;
  assign at_a = addr_hit(wr_addr[15:0], UNLOCK_A);
  assign at_b = addr_hit(wr_addr[15:0], UNLOCK_B);

  always_comb begin
    nxt       = st;
    req_valid = 1'b0;
    req_op    = OP_NONE;
    id_enter  = 1'b0;
    id_exit   = 1'b0;
    if (take) begin
      nxt = S_IDLE;
      if (st != S_PGM && wr_data == D_IDOUT) id_exit = 1'b1;
      unique case (st)
        S_IDLE: if (at_a && wr_data == D_KEY1) nxt = S_UNL1;
        S_UNL1: if (at_b && wr_data == D_KEY2) nxt = S_UNL2;
        S_UNL2: if (at_a) begin
          if (wr_data == D_PROG)       nxt = S_PGM;
          else if (wr_data == D_ERASE) nxt = S_ERA1;
          else if (wr_data == D_IDIN)  id_enter = 1'b1;
        end
        S_PGM: begin
          req_valid = 1'b1;
          req_op    = OP_PROG;
        end
        S_ERA1: if (at_a && wr_data == D_KEY1) nxt = S_ERA2;
        S_ERA2: if (at_b && wr_data == D_KEY2) nxt = S_ERA3;
        S_ERA3: begin
          if (wr_data == D_SECT) begin
            req_valid = 1'b1; req_op = OP_SECT;
          end else if (wr_data == D_BLK) begin
            req_valid = 1'b1; req_op = OP_BLK;
          end else if (wr_data == D_CHIP && at_a && prog_mode) begin
            req_valid = 1'b1; req_op = OP_CHIP;
          end
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_IDLE;
    else        st <= nxt;

  // R9: a busy engine freezes the sequence position.
  a_r9_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |=> $stable(st));
  // R6: a request is only ever produced from a fully unlocked state.
  a_r6_req_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (st == S_PGM || st == S_ERA3));
endmodule

// File: rtl/fcd_guard.sv
module fcd_guard
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BOOT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  fcd_op_e           req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              boot_lock_n,
  input  logic              wp_n,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data
);
  logic in_boot, allow;

  assign in_boot = top_block(32'(req_addr), ADDR_W, BOOT_W);
  assign allow   = (req_op == OP_CHIP) ? (boot_lock_n & wp_n)
                 : (in_boot ? boot_lock_n : wp_n);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= req_valid & allow;
      if (req_valid) begin
        cmd_op   <= req_op;
        cmd_addr <= req_addr;
        cmd_data <= req_data;
      end
    end

  // R2: commands need several writes, so a pulse never lasts two cycles.
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  // R7: a boot-block command only leaves while the lock pin was high.
  a_r7_boot_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op != 3'(OP_CHIP) && top_block(32'(cmd_addr), ADDR_W, BOOT_W))
      |-> $past(boot_lock_n));
  // R8: other blocks only while write protect was high.
  a_r8_wp_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op != 3'(OP_CHIP) && !top_block(32'(cmd_addr), ADDR_W, BOOT_W))
      |-> $past(wp_n));
  // R12: chip erase needs both pins high.
  a_r12_chip_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'(OP_CHIP)) |-> $past(boot_lock_n && wp_n));
endmodule

// File: rtl/fcd_id.sv
module fcd_id
  import fcd_pkg::*;
#(
  parameter logic [7:0] DEV_CODE = 8'h6E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       id_enter,
  input  logic       id_exit,
  input  logic       id_offset,
  output logic       id_mode,
  output logic [7:0] id_code
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        id_mode <= 1'b0;
    else if (id_exit)  id_mode <= 1'b0;
    else if (id_enter) id_mode <= 1'b1;

  always_comb
    if (!id_mode)       id_code = 8'h00;
    else if (id_offset) id_code = DEV_CODE;
    else                id_code = MFR_CODE;

  // R10: entry and exit never coincide.
  a_r10_entry_exit_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(id_enter && id_exit));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int         ADDR_W   = 19,
  parameter int         BOOT_W   = 16,
  parameter logic [7:0] DEV_CODE = 8'h6E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              prog_mode,
  input  logic              boot_lock_n,
  input  logic              wp_n,
  input  logic              erase_busy,
  input  logic              id_offset,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data,
  output logic              id_mode,
  output logic [7:0]        id_code
);
  logic    req_valid, id_enter, id_exit;
  fcd_op_e req_op;

  fcd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .prog_mode, .erase_busy,
    .req_valid, .req_op, .id_enter, .id_exit
  );

  fcd_guard #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_guard (
    .clk, .rst_n, .req_valid, .req_op, .req_addr(wr_addr), .req_data(wr_data),
    .boot_lock_n, .wp_n, .cmd_valid, .cmd_op, .cmd_addr, .cmd_data
  );

  fcd_id #(.DEV_CODE(DEV_CODE)) u_id (
    .clk, .rst_n, .id_enter, .id_exit, .id_offset, .id_mode, .id_code
  );

  // R10: identification mode rises only after a 90h write.
  a_r10_rise_on_90: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> $past(wr_en && !erase_busy && wr_data == D_IDIN));
  // R11: identification mode falls only after an F0h write.
  a_r11_fall_on_f0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(id_mode) |-> $past(wr_en && !erase_busy && wr_data == D_IDOUT));
  // R4: chip erase only leaves while the programmer interface was selected.
  a_r4_chip_prog_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'(OP_CHIP)) |-> $past(prog_mode));
endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  localparam int AW = 19;
  localparam logic [7:0] DEV = 8'h6E;

  typedef struct {
    logic [2:0]    op;
    logic [AW-1:0] addr;
    logic [7:0]    data;
    string         req;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, prog_mode = 0, boot_lock_n = 1, wp_n = 1, erase_busy = 0, id_offset = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic cmd_valid, id_mode;
  logic [2:0] cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [7:0] cmd_data, id_code;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  exp_t sb[$];

  always #10 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .BOOT_W(16), .DEV_CODE(DEV)) i_flash_cmd_decoder (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .prog_mode, .boot_lock_n, .wp_n,
    .erase_busy, .id_offset, .cmd_valid, .cmd_op, .cmd_addr, .cmd_data, .id_mode, .id_code
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic unlock();
    wr(19'h05555, 8'hAA);
    wr(19'h02AAA, 8'h55);
  endtask

  task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d);
    unlock();
    wr(19'h05555, 8'hA0);
    wr(a, d);
  endtask

  task automatic erase(input logic [AW-1:0] a, input logic [7:0] d);
    unlock();
    wr(19'h05555, 8'h80);
    unlock();
    wr(a, d);
  endtask

  task automatic expect_cmd(input logic [2:0] op, input logic [AW-1:0] a,
                            input logic [7:0] d, input string req);
    exp_t e;
    e.op = op; e.addr = a; e.data = d; e.req = req;
    sb.push_back(e);
  endtask

  task automatic settle(input string req);
    repeat (3) @(negedge clk);
    check({req, " all expected commands seen"}, sb.size(), 0);
    sb.delete();
  endtask

  // Monitor: pops and compares each command pulse.
  always @(negedge clk) begin
    #1;
    if (rst_n && cmd_valid) begin
      if (sb.size() == 0) begin
        check({cur_req, " unexpected command"}, 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.req, " op"}, cmd_op, e.op);
        check({e.req, " addr"}, cmd_addr, e.addr);
        check({e.req, " data"}, cmd_data, e.data);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 cmd_valid", cmd_valid, 0);
    check("R1 id_mode", id_mode, 0);
    check("R1 id_code", id_code, 0);
    rst_n = 1;

    cur_req = "R2";
    expect_cmd(3'd1, 19'h12345, 8'h3C, "R2 program");
    program_byte(19'h12345, 8'h3C);
    expect_cmd(3'd1, 19'h00010, 8'hF0, "R2 program F0 data");
    program_byte(19'h00010, 8'hF0);
    settle("R2");

    cur_req = "R3";
    expect_cmd(3'd2, 19'h23000, 8'h30, "R3 sector erase");
    erase(19'h23000, 8'h30);
    expect_cmd(3'd3, 19'h20000, 8'h50, "R3 block erase");
    erase(19'h20000, 8'h50);
    settle("R3");

    cur_req = "R4";
    erase(19'h05555, 8'h10);          // prog_mode 0: dropped
    settle("R4 no chip erase outside programmer mode");
    prog_mode = 1;
    expect_cmd(3'd4, 19'h05555, 8'h10, "R4 chip erase");
    erase(19'h05555, 8'h10);
    settle("R4");

    cur_req = "R12";
    wp_n = 0;
    erase(19'h05555, 8'h10);
    wp_n = 1; boot_lock_n = 0;
    erase(19'h05555, 8'h10);
    boot_lock_n = 1; prog_mode = 0;
    settle("R12 chip erase dropped");

    cur_req = "R5";
    expect_cmd(3'd1, 19'h00777, 8'h11, "R5 upper bits ignored");
    wr(19'h35555, 8'hAA); wr(19'h62AAA, 8'h55); wr(19'h45555, 8'hA0); wr(19'h00777, 8'h11);
    settle("R5 upper bits");
    wr(19'h0D555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0); wr(19'h00778, 8'h22);
    settle("R5 bit15 set rejected");

    cur_req = "R6";
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h56); wr(19'h05555, 8'hA0); wr(19'h00100, 8'h01);
    erase(19'h30000, 8'h77);          // wrong final byte
    unlock(); wr(19'h05555, 8'h80); wr(19'h05555, 8'hAA); wr(19'h05555, 8'h55); wr(19'h30000, 8'h30);
    settle("R6 aborted sequences issue nothing");
    expect_cmd(3'd1, 19'h00100, 8'h01, "R6 recovery");
    program_byte(19'h00100, 8'h01);
    settle("R6 recovery");

    cur_req = "R7";
    boot_lock_n = 0;
    program_byte(19'h7A000, 8'h00);
    erase(19'h70000, 8'h30);
    erase(19'h70000, 8'h50);
    expect_cmd(3'd1, 19'h12000, 8'h5A, "R7 non-boot passes");
    program_byte(19'h12000, 8'h5A);
    settle("R7");
    boot_lock_n = 1;

    cur_req = "R8";
    wp_n = 0;
    program_byte(19'h12000, 8'h00);
    erase(19'h10000, 8'h50);
    erase(19'h6F000, 8'h30);
    expect_cmd(3'd1, 19'h7FFFF, 8'hA5, "R8 boot passes");
    program_byte(19'h7FFFF, 8'hA5);
    settle("R8");
    wp_n = 1;

    cur_req = "R9";
    unlock();
    erase_busy = 1;
    wr(19'h05555, 8'h30);             // ignored
    wr(19'h04444, 8'hF0);             // ignored
    erase_busy = 0;
    expect_cmd(3'd1, 19'h00abc, 8'h99, "R9 resumed program");
    wr(19'h05555, 8'hA0); wr(19'h00abc, 8'h99);
    settle("R9");
    unlock(); wr(19'h05555, 8'hA0);
    erase_busy = 1;
    wr(19'h00def, 8'h12);             // target write ignored while busy
    settle("R9 no command while busy");
    erase_busy = 0;
    expect_cmd(3'd1, 19'h00def, 8'h34, "R9 target after busy");
    wr(19'h00def, 8'h34);
    settle("R9 target after busy");

    cur_req = "R10";
    unlock(); wr(19'h05555, 8'h90);
    #1;
    check("R10 id_mode set", id_mode, 1);
    id_offset = 0; #1;
    check("R10 manufacturer code", id_code, 8'h9D);
    id_offset = 1; #1;
    check("R10 device code", id_code, DEV);

    cur_req = "R11";
    wr(19'h01234, 8'hF0);
    #1;
    check("R11 single F0 exit", id_mode, 0);
    check("R10 id_code zero outside id mode", id_code, 0);
    unlock(); wr(19'h05555, 8'h90);
    #1;
    check("R11 re-entry", id_mode, 1);
    unlock(); wr(19'h05555, 8'hF0);
    #1;
    check("R11 three-write exit", id_mode, 0);
    settle("R11");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule